// File: doc/BRIEF.md
# CPU Doze Rate Controller

This block produces a per-cycle execute enable for a CPU core whose clock runs at the same full rate as the peripherals. When dozing is switched on, the core is allowed to execute only one cycle out of every N, where N is a power of two selected by a small ratio field. When dozing is off, the enable stays high on every cycle.

Two policy bits let the controller leave or re-enter the throttled mode by itself. The first is the wake-on-interrupt bit. If it is set when the interrupt controller reports that an interrupt is being taken, hardware clears the doze-enable bit and the core runs at full speed from that very cycle. If it is clear, the service routine runs at the reduced rate. The second is the resume-on-return bit. If it is set when a return-from-interrupt executes, hardware sets the doze-enable bit again.

Software reaches all the control fields through a single write port, and reads them back through a parallel output. The counter that paces the throttled cycles restarts on any register write and on any hardware change to doze enable. This makes the first enabled cycle after such an event predictable.

Top module: `doze_rate_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the control readback is all zeros and the execute enable is high.
- R2: A write stores the control word as laid out: bit 0 doze enable, bit 1 wake-on-interrupt, bit 2 resume-on-return, bits 3 and up the ratio code. From the next cycle the readback shows it in the same layout.
- R3: While the doze-enable bit reads 0, the execute enable is high on every cycle.
- R4: With doze enabled and ratio code k, the execute enable is high exactly one cycle in every 2^(k+1), so code 0 gives 1:2 and code 7 gives 1:256. The first high cycle is the cycle right after the write.
- R5: If an interrupt-taken pulse arrives while wake-on-interrupt reads 1, the execute enable is high in that same cycle, whatever the phase. Doze enable reads 0 from the next cycle on.
- R6: If an interrupt-taken pulse arrives while wake-on-interrupt reads 0, it has no effect: doze enable and the throttling phase continue unchanged.
- R7: A return pulse while resume-on-return reads 1 sets doze enable from the next cycle and restarts the pacing. The execute enable is high in that next cycle and then follows the ratio.
- R8: A return pulse while resume-on-return reads 0 leaves doze enable unchanged.
- R9: When a hardware change to doze enable and a software write happen in the same cycle, the doze-enable bit takes the hardware value. The other fields take the written values.
- R10: When an interrupt-taken pulse (with wake-on-interrupt 1) and a return pulse (with resume-on-return 1) coincide, clearing wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Full-rate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | RATIO_W+3 | Control word to write |
| irq_take | input | 1 | One-cycle pulse: interrupt being taken |
| irq_return | input | 1 | One-cycle pulse: return from interrupt executes |
| cpu_exec_en | output | 1 | CPU may execute in this cycle |
| cfg_rdata | output | RATIO_W+3 | Current control word |

## Verification
A wrong pacing counter shows at the execute enable within one doze period. The longest case is 256 cycles at the slowest code. A stuck or mis-set policy bit shows in the readback on the cycle after the interrupt or return pulse that it governs. A missing same-cycle recovery shows as a low enable in the pulse cycle itself. The reference model therefore compares the enable and the readback on every clock, and places pulses at several phases of a doze period.

// File: rtl/doze_pkg.sv
package doze_pkg;
   // Field positions inside the control word
   localparam int unsigned FLD_EN    = 0;
   localparam int unsigned FLD_WAKE  = 1;
   localparam int unsigned FLD_RESUM = 2;
   localparam int unsigned FLD_RATIO = 3;

   typedef enum logic [1:0] {
      HW_NONE  = 2'd0,
      HW_CLEAR = 2'd1,
      HW_SET   = 2'd2
   } hw_act_e;
endpackage

// File: rtl/doze_event_arb.sv
module doze_event_arb
   import doze_pkg::*;
(
   input  logic    irq_take,
   input  logic    irq_return,
   input  logic    wake_q,
   input  logic    resum_q,
   output hw_act_e act
);
   // Clearing (recovery) outranks re-entry when both occur together
   always_comb begin
      if (irq_take && wake_q)
         act = HW_CLEAR;
      else if (irq_return && resum_q)
         act = HW_SET;
      else
         act = HW_NONE;
   end
endmodule

// File: rtl/doze_cfg_reg.sv
module doze_cfg_reg
   import doze_pkg::*;
#(
   parameter int unsigned RATIO_W = 3,
   localparam int unsigned CFG_W  = RATIO_W + 3
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [CFG_W-1:0]   wr_data,
   input  hw_act_e            act,
   output logic               doze_en,
   output logic               wake,
   output logic               resum,
   output logic [RATIO_W-1:0] ratio,
   output logic               restart
);
   logic               en_d;
   logic               wake_d;
   logic               resum_d;
   logic [RATIO_W-1:0] ratio_d;

   always_comb begin
      en_d    = doze_en;
      wake_d  = wake;
      resum_d = resum;
      ratio_d = ratio;
      if (wr_en) begin
         en_d    = wr_data[FLD_EN];
         wake_d  = wr_data[FLD_WAKE];
         resum_d = wr_data[FLD_RESUM];
         ratio_d = wr_data[FLD_RATIO +: RATIO_W];
      end
      // hardware owns the enable bit over software in the same cycle
      unique case (act)
         HW_CLEAR: en_d = 1'b0;
         HW_SET:   en_d = 1'b1;
         default:  ;
      endcase
   end

   assign restart = wr_en || (act != HW_NONE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         doze_en <= 1'b0;
         wake    <= 1'b0;
         resum   <= 1'b0;
         ratio   <= '0;
      end else begin
         doze_en <= en_d;
         wake    <= wake_d;
         resum   <= resum_d;
         ratio   <= ratio_d;
      end
   end
endmodule

// File: rtl/doze_period_cnt.sv
module doze_period_cnt #(
   parameter int unsigned RATIO_W    = 3,
   parameter int unsigned WRAP_STYLE = 0,
   localparam int unsigned CNT_W     = 1 << RATIO_W
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               run,
   input  logic               restart,
   input  logic [RATIO_W-1:0] ratio,
   output logic               phase_zero
);
   logic [CNT_W-1:0] last;   // period - 1, as a low-bit mask
   logic [CNT_W-1:0] cnt_q;

   always_comb begin
      for (int i = 0; i < CNT_W; i++)
         last[i] = (i <= int'(ratio));
   end

   assign phase_zero = (cnt_q == '0);

   generate
      if (WRAP_STYLE == 0) begin : g_up
         always_ff @(posedge clk) begin
            if (!rst_n || restart || !run)
               cnt_q <= '0;
            else if (cnt_q == last)
               cnt_q <= '0;
            else
               cnt_q <= cnt_q + 1'b1;
         end
      end else begin : g_down
         always_ff @(posedge clk) begin
            if (!rst_n || restart || !run)
               cnt_q <= '0;
            else if (cnt_q == '0)
               cnt_q <= last;
            else
               cnt_q <= cnt_q - 1'b1;
         end
      end
   endgenerate
endmodule

// File: rtl/doze_rate_ctrl.sv
module doze_rate_ctrl
   import doze_pkg::*;
#(
   parameter int unsigned RATIO_W    = 3,
   parameter int unsigned WRAP_STYLE = 0,
   localparam int unsigned CFG_W     = RATIO_W + 3
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [CFG_W-1:0] cfg_wdata,
   input  logic             irq_take,
   input  logic             irq_return,
   output logic             cpu_exec_en,
   output logic [CFG_W-1:0] cfg_rdata
);
   generate
      if (RATIO_W < 1 || RATIO_W > 4) begin : g_bad_ratio_w
         $error("doze_rate_ctrl: RATIO_W must lie in 1..4");
      end
      if (WRAP_STYLE > 1) begin : g_bad_wrap
         $error("doze_rate_ctrl: WRAP_STYLE must be 0 or 1");
      end
   endgenerate

   hw_act_e            act;
   logic               doze_en;
   logic               wake;
   logic               resum;
   logic [RATIO_W-1:0] ratio;
   logic               restart;
   logic               phase_zero;

   doze_event_arb u_arb (
      .irq_take   (irq_take),
      .irq_return (irq_return),
      .wake_q     (wake),
      .resum_q    (resum),
      .act        (act)
   );

   doze_cfg_reg #(.RATIO_W(RATIO_W)) u_cfg (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (cfg_we),
      .wr_data (cfg_wdata),
      .act     (act),
      .doze_en (doze_en),
      .wake    (wake),
      .resum   (resum),
      .ratio   (ratio),
      .restart (restart)
   );

   doze_period_cnt #(.RATIO_W(RATIO_W), .WRAP_STYLE(WRAP_STYLE)) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .run        (doze_en),
      .restart    (restart),
      .ratio      (ratio),
      .phase_zero (phase_zero)
   );

   // recovery lets the pulse cycle itself execute
   assign cpu_exec_en = !doze_en || phase_zero || (act == HW_CLEAR);

   always_comb begin
      cfg_rdata = '0;
      cfg_rdata[FLD_EN]               = doze_en;
      cfg_rdata[FLD_WAKE]             = wake;
      cfg_rdata[FLD_RESUM]            = resum;
      cfg_rdata[FLD_RATIO +: RATIO_W] = ratio;
   end
endmodule

// File: rtl/doze_rate_ctrl_chk.sv
module doze_rate_ctrl_chk #(
   parameter int unsigned RATIO_W = 3,
   localparam int unsigned CFG_W  = RATIO_W + 3
)(
   input logic             clk,
   input logic             rst_n,
   input logic             cfg_we,
   input logic [CFG_W-1:0] cfg_wdata,
   input logic             irq_take,
   input logic             irq_return,
   input logic             cpu_exec_en,
   input logic [CFG_W-1:0] cfg_rdata
);
   logic hw_clr;
   logic hw_set;
   assign hw_clr = irq_take && cfg_rdata[1];
   assign hw_set = irq_return && cfg_rdata[2] && !hw_clr;

   // R3
   assert_full_speed_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_rdata[0] |-> cpu_exec_en);

   // R5
   assert_wake_same_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
      hw_clr |-> cpu_exec_en);

   // R5 and R10
   assert_wake_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
      hw_clr |=> !cfg_rdata[0]);

   // R7 and R9
   assert_resume_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
      hw_set |=> (cfg_rdata[0] && cpu_exec_en));

   // R6 and R8
   assert_no_policy_no_change_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_we && !hw_clr && !hw_set) |=> $stable(cfg_rdata));

   // R2
   assert_write_stored_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && !hw_clr && !hw_set) |=> (cfg_rdata == $past(cfg_wdata)));

   // R4: a throttled enable cycle is followed by at least one idle cycle
   assert_gap_after_run_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_rdata[0] && cpu_exec_en && !cfg_we && !irq_take && !irq_return)
      |=> (!cpu_exec_en || (irq_take && cfg_rdata[1]) || !cfg_rdata[0]));
endmodule

bind doze_rate_ctrl doze_rate_ctrl_chk #(.RATIO_W(RATIO_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cfg_we      (cfg_we),
   .cfg_wdata   (cfg_wdata),
   .irq_take    (irq_take),
   .irq_return  (irq_return),
   .cpu_exec_en (cpu_exec_en),
   .cfg_rdata   (cfg_rdata)
);

// File: tb/doze_rate_ctrl_bench.sv
`timescale 1ns/100ps
module doze_rate_ctrl_bench;
   localparam int CFG_W = 6;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             cfg_we = 1'b0;
   logic [CFG_W-1:0] cfg_wdata = '0;
   logic             irq_take = 1'b0;
   logic             irq_return = 1'b0;
   logic             cpu_exec_en;
   logic [CFG_W-1:0] cfg_rdata;

   int compared = 0;
   int mismatched = 0;

   // reference state
   int m_doze = 0, m_wake = 0, m_resum = 0, m_ratio = 0, m_phase = 0;

   always #2.5 clk = ~clk;

   doze_rate_ctrl u_doze_rate_ctrl (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
      .irq_take(irq_take), .irq_return(irq_return),
      .cpu_exec_en(cpu_exec_en), .cfg_rdata(cfg_rdata)
   );

   function automatic logic [CFG_W-1:0] word(int en, int wk, int rs, int k);
      logic [CFG_W-1:0] w;
      w = '0;
      w[0] = en[0]; w[1] = wk[0]; w[2] = rs[0]; w[5:3] = k[2:0];
      return w;
   endfunction

   task automatic check(input string tag);
      logic exp_en;
      logic [CFG_W-1:0] exp_rd;
      exp_en = (m_doze == 0) || (m_phase == 0) || (irq_take && m_wake != 0);
      exp_rd = word(m_doze, m_wake, m_resum, m_ratio);
      compared++;
      if (cpu_exec_en !== exp_en || cfg_rdata !== exp_rd) begin
         mismatched++;
         $display("FAIL %s t=%0t exec_en=%b/%b rdata=%h/%h (actual/expected)",
                  tag, $time, cpu_exec_en, exp_en, cfg_rdata, exp_rd);
      end
   endtask

   task automatic step(input logic we, input logic [CFG_W-1:0] wd,
                       input logic it, input logic ir, input string tag);
      int clr, set, per;
      @(negedge clk);
      cfg_we = we; cfg_wdata = wd; irq_take = it; irq_return = ir;
      #1;
      check(tag);
      @(posedge clk);
      clr = (it && m_wake != 0) ? 1 : 0;
      set = (!clr && ir && m_resum != 0) ? 1 : 0;
      if (we) begin
         m_doze = wd[0]; m_wake = wd[1]; m_resum = wd[2]; m_ratio = int'(wd[5:3]);
      end
      if (clr) m_doze = 0;
      if (set) m_doze = 1;
      per = 2 << m_ratio;
      if (we || clr || set || m_doze == 0) m_phase = 0;
      else m_phase = (m_phase + 1) % per;
   endtask

   task automatic idle(input int n, input string tag);
      for (int i = 0; i < n; i++) step(1'b0, '0, 1'b0, 1'b0, tag);
   endtask

   initial begin
      #(5.0 * 200000);
      mismatched++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      // R1: reset state during and just after reset
      repeat (3) @(negedge clk);
      #1 check("R1");
      @(negedge clk); rst_n = 1'b1;
      idle(1, "R1");
      // R3: doze off -> always executing
      idle(6, "R3");
      // R2: fields written with doze off
      step(1'b1, word(0, 1, 1, 5), 1'b0, 1'b0, "R2");
      idle(4, "R2");
      // R4: ratio codes 0, 2, 7
      step(1'b1, word(1, 0, 0, 0), 1'b0, 1'b0, "R4");
      idle(8, "R4");
      step(1'b1, word(1, 0, 0, 2), 1'b0, 1'b0, "R4");
      idle(20, "R4");
      step(1'b1, word(1, 0, 0, 7), 1'b0, 1'b0, "R4");
      idle(600, "R4");
      // R6: interrupt without wake policy keeps rate
      step(1'b1, word(1, 0, 1, 1), 1'b0, 1'b0, "R6");
      idle(2, "R6");
      step(1'b0, '0, 1'b1, 1'b0, "R6");
      idle(10, "R6");
      // R5: wake in the second cycle of a period
      step(1'b1, word(1, 1, 0, 2), 1'b0, 1'b0, "R5");
      idle(1, "R5");
      step(1'b0, '0, 1'b1, 1'b0, "R5");
      idle(10, "R5");
      // R8: return without resume policy
      step(1'b0, '0, 1'b0, 1'b1, "R8");
      idle(5, "R8");
      // R7: return with resume policy re-enters doze
      step(1'b1, word(0, 1, 1, 1), 1'b0, 1'b0, "R7");
      step(1'b0, '0, 1'b0, 1'b1, "R7");
      idle(12, "R7");
      // R5: wake at a later phase of a long period
      step(1'b1, word(1, 1, 1, 3), 1'b0, 1'b0, "R5");
      idle(9, "R5");
      step(1'b0, '0, 1'b1, 1'b0, "R5");
      idle(4, "R5");
      // R9: hardware set beats software clear, other fields from write
      step(1'b0, '0, 1'b0, 1'b1, "R9");
      idle(3, "R9");
      step(1'b1, word(0, 1, 1, 4), 1'b0, 1'b1, "R9");
      idle(6, "R9");
      // R9: hardware clear beats software set
      step(1'b1, word(1, 1, 1, 1), 1'b1, 1'b0, "R9");
      idle(4, "R9");
      // R10: both pulses together, clear wins
      step(1'b0, '0, 1'b0, 1'b1, "R10");
      idle(2, "R10");
      step(1'b0, '0, 1'b1, 1'b1, "R10");
      idle(4, "R10");
      // mixed traffic
      for (int i = 0; i < 3000; i++) begin
         logic we, it, ir;
         logic [CFG_W-1:0] wd;
         we = ($urandom_range(0, 39) == 0);
         it = ($urandom_range(0, 29) == 0);
         ir = ($urandom_range(0, 29) == 0);
         wd = CFG_W'($urandom);
         step(we, wd, it, ir, "R4");
      end
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule